// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status-Carrying FIFO

The block recovers characters from an asynchronous serial line and queues them in a two-slot circular buffer. Each slot holds the data byte together with the flags that belong to it: the ninth data bit, the framing error and the overrun indication. Software therefore reads the status port first and pops the character afterwards; after the pop, the status port shows the next character's flags. The line is oversampled by an external tick, so the clock divider is not part of this block.

When both slots are occupied, a newly finished character waits in the receive shift stage, which acts as a third level of storage. That character is dropped only when the next start bit appears while it is still waiting. The next character stored after the drop then carries the overrun flag.

A single write port models one shared register location. The top bit of the written value selects the target: a 0 writes the high byte of the baud divisor, and a 1 writes the control register. Bit 0 of the control register selects 9-bit characters.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset, `avail`, `data_out`, `stat_out`, `baud_hi` and `ctrl` are all zero, so the stored ninth bit starts at 0.
- R2: A frame has one low start bit, data sent LSB first and one stop bit. After such a frame, `avail` is high and `data_out` shows the byte. In 8-bit mode (`ctrl[0]`=0) the ninth-bit flag `stat_out[0]` is 0.
- R3: In 9-bit mode (`ctrl[0]`=1), the ninth data bit on the line is stored with its byte and shown on `stat_out[0]`.
- R4: A stop bit sampled low sets the framing flag `stat_out[1]` for that character only.
- R5: The two slots are read in arrival order. Each `rd_data` pulse pops exactly one entry, and `avail` falls once the last entry is popped.
- R6: A third character that arrives while both slots are full waits in the shift stage. It enters the buffer in the clock after a pop and is read back intact, with no overrun flag.
- R7: A waiting character is lost if a new start bit is detected before a slot frees. The next character stored after the loss carries the overrun flag `stat_out[2]`, and that flag leaves with the pop of that entry.
- R8: A low pulse shorter than half a bit period is not taken as a start bit and produces no character.
- R9: A register write with bit 7 = 0 loads `baud_hi` from bits 6:0. A write with bit 7 = 1 loads `ctrl` from bits 6:0. The register not selected keeps its value.
- R10: A `rd_data` pulse while the buffer is empty has no effect: the next character is still read correctly, and nothing follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | 1 | Serial line, idles high |
| tick | input | 1 | Oversampling strobe, 16 per bit |
| rd_data | input | 1 | Pops the head entry |
| reg_wr | input | 1 | Write strobe for the shared register location |
| reg_wdata | input | 8 | Write value; bit 7 selects the target |
| data_out | output | 8 | Head entry byte |
| stat_out | output | 3 | Head flags: {overrun, framing, ninth bit} |
| avail | output | 1 | At least one entry queued |
| baud_hi | output | 7 | High baud-divisor byte |
| ctrl | output | 7 | Control register; bit 0 selects 9-bit mode |

## Verification
A character is complete at the middle of its stop bit, and it enters the buffer in the same edge unless both slots are full. A parked character moves in one clock after the pop that frees a slot. For that reason the bench samples results only after the whole stop bit and an idle bit have gone by, and it waits three clocks after each pop. Register writes show on the outputs one clock after the strobe, so they are checked at the next falling edge. The expected characters, including which one is lost and which carries the overrun flag, are queued by the sending task and compared against the head outputs before every pop.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick,
  input  logic       rd_data,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] data_out,
  output logic [2:0] stat_out,
  output logic       avail,
  output logic [6:0] baud_hi,
  output logic [6:0] ctrl
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [1:0]    rx_sy;
  logic          rx_s;
  st_t           st;
  logic [CW-1:0] sc;
  logic [3:0]    bn;
  logic [8:0]    sh;
  logic          nine;
  logic [3:0]    nlast;
  logic          done;
  logic [9:0]    word;
  logic [9:0]    hold;
  logic          hold_valid, ovr_pend;
  logic [10:0]   mem [0:1];
  logic          wp, rp;
  logic [1:0]    count;
  logic          start_det, push, pop, lose;

  assign rx_s      = rx_sy[1];
  assign nine      = ctrl[0];
  assign nlast     = nine ? 4'd8 : 4'd7;
  assign start_det = (st == S_IDLE) && !rx_s;
  assign push      = hold_valid && (count != 2'd2);
  assign pop       = rd_data && (count != 2'd0);
  assign lose      = start_det && hold_valid && !push;
  assign done      = (st == S_STOP) && tick && (sc == LAST);
  assign word      = {!rx_s, nine & sh[8], nine ? sh[7:0] : sh[8:1]};

  assign avail    = count != 2'd0;
  assign data_out = avail ? mem[rp][7:0]  : 8'd0;
  assign stat_out = avail ? mem[rp][10:8] : 3'd0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sy <= 2'b11;
    else        rx_sy <= {rx_sy[0], rx_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sc <= '0;
      bn <= '0;
      sh <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (!rx_s) begin
            st <= S_START;
            sc <= '0;
          end
        S_START:
          if (tick) begin
            if (sc == MID) begin
              st <= rx_s ? S_IDLE : S_DATA;
              sc <= '0;
              bn <= '0;
            end else sc <= sc + 1'b1;
          end
        S_DATA:
          if (tick) begin
            if (sc == LAST) begin
              sc <= '0;
              sh <= {rx_s, sh[8:1]};
              bn <= bn + 4'd1;
              if (bn == nlast) st <= S_STOP;
            end else sc <= sc + 1'b1;
          end
        default:
          if (tick) begin
            if (sc == LAST) begin
              st <= S_IDLE;
              sc <= '0;
            end else sc <= sc + 1'b1;
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold       <= '0;
      hold_valid <= 1'b0;
      ovr_pend   <= 1'b0;
    end else begin
      if (done) begin
        hold       <= word;
        hold_valid <= 1'b1;
      end else if (push || lose) hold_valid <= 1'b0;
      if (lose)      ovr_pend <= 1'b1;
      else if (push) ovr_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem[0] <= '0;
      mem[1] <= '0;
      wp     <= 1'b0;
      rp     <= 1'b0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wp] <= {ovr_pend, hold};
        wp      <= ~wp;
      end
      if (pop) rp <= ~rp;
      count <= count + {1'b0, push} - {1'b0, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_hi <= '0;
      ctrl    <= '0;
    end else if (reg_wr) begin
      if (reg_wdata[7]) ctrl    <= reg_wdata[6:0];
      else              baud_hi <= reg_wdata[6:0];
    end
  end
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data,
  input logic       reg_wr,
  input logic       avail,
  input logic [6:0] baud_hi,
  input logic [6:0] ctrl,
  input logic       push,
  input logic       lose,
  input logic       ovr_pend,
  input logic       hold_valid,
  input logic [1:0] count
);
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && rd_data && !push) |=> !avail);
  a_r2_push_avail: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> avail);
  a_r5_two_slots: assert property (@(posedge clk) disable iff (!rst_n)
    count != 2'd3);
  a_r6_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 2'd2 && hold_valid && !lose) |=> hold_valid);
  a_r7_loss_pending: assert property (@(posedge clk) disable iff (!rst_n)
    lose |=> ovr_pend);
  a_r9_regs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> ($stable(baud_hi) && $stable(ctrl)));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .reg_wr(reg_wr),
  .avail(avail), .baud_hi(baud_hi), .ctrl(ctrl), .push(push),
  .lose(lose), .ovr_pend(ovr_pend), .hold_valid(hold_valid), .count(count)
);

// File: tb/uart_rx_fifo_bench.sv
module uart_rx_fifo_bench;
  logic       clk = 0, rst_n = 0, rx_in = 1, tick = 0, rd_data = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] data_out;
  logic [2:0] stat_out;
  logic       avail;
  logic [6:0] baud_hi, ctrl;

  int n_cmp = 0, n_bad = 0;
  logic [10:0] exp_q[$];

  uart_rx_fifo u_uart_rx_fifo (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .tick(tick), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .data_out(data_out),
    .stat_out(stat_out), .avail(avail), .baud_hi(baud_hi), .ctrl(ctrl)
  );

  always #10 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bitwait();
    repeat (32) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input bit nine,
                      input bit stop_ok, input bit ovr, input bit keep);
    rx_in = 0; bitwait();
    for (int i = 0; i < 8; i++) begin rx_in = d[i]; bitwait(); end
    if (nine) begin rx_in = b9; bitwait(); end
    rx_in = stop_ok; bitwait();
    rx_in = 1; bitwait();
    if (keep) exp_q.push_back({ovr, !stop_ok, nine & b9, d});
  endtask

  task automatic monitor_pop(input string tag);
    logic [10:0] e;
    @(negedge clk);
    if (exp_q.size() == 0) begin
      check(0, {tag, " queue empty"}, 0, 0);
      return;
    end
    e = exp_q.pop_front();
    check(avail === 1'b1, {tag, " avail"}, avail, 1);
    check({stat_out, data_out} === e, tag, {stat_out, data_out}, e);
    rd_data = 1; @(negedge clk); rd_data = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wreg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check({avail, stat_out, data_out, baud_hi, ctrl} === '0, "R1 reset state",
          {avail, stat_out, data_out, baud_hi, ctrl}, 0);

    wreg(8'h05);
    check(baud_hi === 7'h05 && ctrl === 7'h00, "R9 baud write", {baud_hi, ctrl}, {7'h05, 7'h00});
    wreg(8'h81);
    check(baud_hi === 7'h05 && ctrl === 7'h01, "R9 ctrl write", {baud_hi, ctrl}, {7'h05, 7'h01});
    wreg(8'h80);
    check(ctrl === 7'h00 && baud_hi === 7'h05, "R9 ctrl clear", {baud_hi, ctrl}, {7'h05, 7'h00});

    @(negedge clk); rd_data = 1; @(negedge clk); rd_data = 0;
    check(avail === 1'b0, "R10 empty read", avail, 0);
    send(8'hA5, 0, 0, 1, 0, 1);
    monitor_pop("R10 after empty read");
    check(avail === 1'b0, "R10 single entry", avail, 0);

    send(8'h3C, 1, 0, 1, 0, 1);
    monitor_pop("R2 8-bit frame");

    wreg(8'h81);
    send(8'h5A, 1, 1, 1, 0, 1);
    send(8'hF0, 0, 1, 1, 0, 1);
    monitor_pop("R3 ninth set");
    monitor_pop("R3 ninth clear");
    wreg(8'h80);

    send(8'h77, 0, 0, 0, 0, 1);
    monitor_pop("R4 framing error");
    send(8'h11, 0, 0, 1, 0, 1);
    monitor_pop("R4 clean after error");

    rx_in = 0; repeat (8) @(negedge clk); rx_in = 1;
    repeat (400) @(negedge clk);
    check(avail === 1'b0, "R8 glitch ignored", avail, 0);
    send(8'h42, 0, 0, 1, 0, 1);
    monitor_pop("R8 frame after glitch");

    send(8'hA1, 0, 0, 1, 0, 1);
    send(8'hB2, 0, 0, 1, 0, 1);
    send(8'hC3, 0, 0, 1, 0, 1);
    monitor_pop("R5 first in order");
    check(avail === 1'b1, "R6 parked moved in", avail, 1);
    monitor_pop("R5 second in order");
    monitor_pop("R6 parked frame");
    check(avail === 1'b0, "R5 drained", avail, 0);

    send(8'hD1, 0, 0, 1, 0, 1);
    send(8'hE2, 0, 0, 1, 0, 1);
    send(8'hF3, 0, 0, 1, 0, 0);
    send(8'h64, 0, 0, 1, 1, 1);
    monitor_pop("R7 head before loss");
    monitor_pop("R7 second before loss");
    monitor_pop("R7 overrun flagged");
    check(avail === 1'b0 && stat_out === 3'd0, "R7 flag popped", {avail, stat_out}, 0);
    send(8'h55, 0, 0, 1, 0, 1);
    monitor_pop("R7 flag cleared");

    check(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule